// File: doc/BRIEF.md
# Environmental Event Status and Control Register

This block is one 16-bit status and control word for platform health events: CPU temperature failure and recovery, enclosure fan failure, critical enclosure temperature, a critical CPU fan failure, and changes in the two power-supply status inputs. Each event input goes through an edge detector and sets a status bit. Software reads the whole word on `rd_data` and updates it with single-cycle writes on `wr_en`/`wr_data`. Two interrupt lines leave the block. `irq_o` is the maskable request, and it covers the temperature, fan and supply-change events. `nmi_o` is the non-maskable request, and it covers the two critical events. A third output, `power_off_o`, requests that system power be switched off.

The three ordinary event bits and the two supply-change bits are write-one-to-clear. A fresh edge on the source sets the bit again, so a temperature sensor that drops and comes back raises a new event. A fan input is a single pulse and sets the bit once. The two critical bits cannot be cleared by software. Only their mask hides them, and only a reset clears them. Three separate mask bits gate three groups of sources. All event inputs are assumed to be synchronous to `clk` already.

Top module: `envmon_status_reg`

## Requirements
- R1: During reset and on the first cycle after it, `rd_data` reads 16'h0160: mask bits 5, 6 and 8 are 1 and every other bit is 0. `irq_o`, `nmi_o` and `power_off_o` are 0. A source that is already high when reset is released does not set a bit.
- R2: A rising edge on `cpu_temp_ok_in`, `cpu_temp_fail_in` or `encl_fan_fail_in` sets bit 0, 1 or 2 respectively on the next clock edge. A source that stays high does not set its bit again after the bit is cleared.
- R3: A write with a 1 in bit 0, 1, 2, 9 or 10 clears that bit, and a 0 in those positions leaves the bit unchanged. If a new source edge arrives in the same cycle as a clearing write, the bit ends up set.
- R4: Bit 9 and bit 10 are set by either a rising or a falling edge of `psu1_good_in` and `psu2_good_in` respectively.
- R5: A rising edge on `encl_temp_crit_in` or `cpu_fan_crit_in` sets bit 3 or bit 4 respectively. Writes never change these bits, and once set they stay set until reset.
- R6: `irq_o` = (any of bits 0..2 set AND bit 5 == 0) OR (bit 9 or bit 10 set AND bit 8 == 0).
- R7: `nmi_o` = (bit 3 or bit 4 set) AND bit 6 == 0.
- R8: Bit 7 is read/write, and `power_off_o` follows its value.
- R9: Bits 15..11 always read 0, and writes to them have no effect.
- R10: Mask bits 5, 6 and 8 are read/write and take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register value |
| cpu_temp_ok_in | input | 1 | CPU temperature restored event source |
| cpu_temp_fail_in | input | 1 | CPU temperature failure event source |
| encl_fan_fail_in | input | 1 | Enclosure fan failure pulse |
| encl_temp_crit_in | input | 1 | Critical enclosure temperature source |
| cpu_fan_crit_in | input | 1 | Critical CPU fan source |
| psu1_good_in | input | 1 | Supply 1 status level |
| psu2_good_in | input | 1 | Supply 2 status level |
| irq_o | output | 1 | Maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |
| power_off_o | output | 1 | Power-off request |

## Verification
The bench uses the default widths: three ordinary sources, two critical sources and two supply inputs. That makes the input space small enough to sweep completely. For every one of the 8 mask combinations, it drives every one of the 128 event patterns from reset. It then checks the full read word and both interrupt lines, first after the events and again after a clear-all write. This covers every interaction between the masks, the sticky critical bits and the write-one-to-clear bits. Directed sequences then cover the remaining cases: a same-cycle edge and clear, a held level, a falling supply edge, power-off writes and a source that is high during reset.

// File: rtl/envmon_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, bit positions and reset value of the
// environmental event register. Assumes a 16-bit register word.
package envmon_pkg;
    localparam int REG_W    = 16;
    localparam int N_SINT   = 3;
    localparam int N_CRIT   = 2;
    localparam int N_PSU    = 2;

    localparam int SINT_LSB = 0;
    localparam int CRIT_LSB = SINT_LSB + N_SINT;
    localparam int SMSK_BIT = CRIT_LSB + N_CRIT;
    localparam int NMSK_BIT = SMSK_BIT + 1;
    localparam int POFF_BIT = NMSK_BIT + 1;
    localparam int PMSK_BIT = POFF_BIT + 1;
    localparam int PSU_LSB  = PMSK_BIT + 1;
    localparam int USED_W   = PSU_LSB + N_PSU;

    typedef struct packed {
        logic sint_mask;
        logic nmi_mask;
        logic psu_mask;
        logic power_off;
    } ctrl_t;

    // Reset value: all masks set, everything else clear.
    function automatic logic [REG_W-1:0] reset_word();
        logic [REG_W-1:0] w;
        w = '0;
        w[SMSK_BIT] = 1'b1;
        w[NMSK_BIT] = 1'b1;
        w[PMSK_BIT] = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/envmon_edge_det.sv
`timescale 1ns/1ps
// Edge detector: one-cycle pulse per lane on a rising edge, or on any
// edge when ANY_EDGE is set. Inputs are assumed synchronous to clk.
// During reset the history register tracks the input, so a level that
// is already present at reset release produces no pulse.
module envmon_edge_det #(
    parameter int W        = 1,
    parameter bit ANY_EDGE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_in,
    output logic [W-1:0] edge_out
);
    logic [W-1:0] prev_q;

    // Keep last sampled level (follows input while in reset).
    always_ff @(posedge clk) begin
        prev_q <= sig_in;
    end

    generate
        if (ANY_EDGE) begin : g_any
            // Pulse on either transition, suppressed in reset.
            always_comb edge_out = rst_n ? (sig_in ^ prev_q) : '0;
        end else begin : g_rise
            // Pulse on low-to-high transition, suppressed in reset.
            always_comb edge_out = rst_n ? (sig_in & ~prev_q) : '0;
        end
    endgenerate
endmodule

// File: rtl/envmon_event_latch.sv
`timescale 1ns/1ps
// Event latch: per-lane status bit set by a pulse. With CLEARABLE set,
// a qualified write-one clears it, and a same-cycle set wins.
// Without CLEARABLE, bits are sticky until reset.
module envmon_event_latch #(
    parameter int W         = 1,
    parameter bit CLEARABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_pulse,
    input  logic [W-1:0] clr_req,
    output logic [W-1:0] state_q
);
    generate
        if (CLEARABLE) begin : g_w1c
            // Clear on request, then apply new events on top.
            always_ff @(posedge clk) begin
                if (!rst_n) state_q <= '0;
                else        state_q <= (state_q & ~clr_req) | set_pulse;
            end
        end else begin : g_sticky
            logic [W-1:0] unused_clr;
            always_comb unused_clr = clr_req;
            // Accumulate events; only reset clears.
            always_ff @(posedge clk) begin
                if (!rst_n) state_q <= '0;
                else        state_q <= state_q | set_pulse;
            end
        end
    endgenerate
endmodule

// File: rtl/envmon_ctrl_reg.sv
`timescale 1ns/1ps
// Control bits: three masks and the power-off request, all plain
// read/write from the register write port. Masks reset to 1.
module envmon_ctrl_reg
    import envmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_t            ctrl_q
);
    // Load control fields on a write; reset to masked, power on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.sint_mask <= 1'b1;
            ctrl_q.nmi_mask  <= 1'b1;
            ctrl_q.psu_mask  <= 1'b1;
            ctrl_q.power_off <= 1'b0;
        end else if (wr_en) begin
            ctrl_q.sint_mask <= wr_data[SMSK_BIT];
            ctrl_q.nmi_mask  <= wr_data[NMSK_BIT];
            ctrl_q.psu_mask  <= wr_data[PMSK_BIT];
            ctrl_q.power_off <= wr_data[POFF_BIT];
        end
    end
endmodule

// File: rtl/envmon_status_reg.sv
`timescale 1ns/1ps
// Top: environmental event status/control register. Edge-detects the
// event sources, latches them (write-one-to-clear or sticky), holds
// masks and power-off, and forms the maskable and NMI requests.
// Assumes all inputs are synchronous to clk.
module envmon_status_reg
    import envmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             cpu_temp_ok_in,
    input  logic             cpu_temp_fail_in,
    input  logic             encl_fan_fail_in,
    input  logic             encl_temp_crit_in,
    input  logic             cpu_fan_crit_in,
    input  logic             psu1_good_in,
    input  logic             psu2_good_in,
    output logic             irq_o,
    output logic             nmi_o,
    output logic             power_off_o
);
    logic [N_SINT-1:0] sint_src, sint_edge, sint_clr, sint_q;
    logic [N_CRIT-1:0] crit_src, crit_edge, crit_clr, crit_q;
    logic [N_PSU-1:0]  psu_src,  psu_edge,  psu_clr,  psu_q;
    ctrl_t             ctrl_q;

    // Gather source pins into lane vectors.
    always_comb begin
        sint_src = {encl_fan_fail_in, cpu_temp_fail_in, cpu_temp_ok_in};
        crit_src = {cpu_fan_crit_in, encl_temp_crit_in};
        psu_src  = {psu2_good_in, psu1_good_in};
    end

    // Qualify write-one-to-clear requests by the write strobe.
    always_comb begin
        sint_clr = wr_en ? wr_data[SINT_LSB +: N_SINT] : '0;
        crit_clr = '0;
        psu_clr  = wr_en ? wr_data[PSU_LSB +: N_PSU] : '0;
    end

    envmon_edge_det #(.W(N_SINT), .ANY_EDGE(1'b0)) u_sint_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(sint_src), .edge_out(sint_edge));
    envmon_edge_det #(.W(N_CRIT), .ANY_EDGE(1'b0)) u_crit_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(crit_src), .edge_out(crit_edge));
    envmon_edge_det #(.W(N_PSU), .ANY_EDGE(1'b1)) u_psu_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(psu_src), .edge_out(psu_edge));

    envmon_event_latch #(.W(N_SINT), .CLEARABLE(1'b1)) u_sint_lat (
        .clk(clk), .rst_n(rst_n), .set_pulse(sint_edge), .clr_req(sint_clr),
        .state_q(sint_q));
    envmon_event_latch #(.W(N_CRIT), .CLEARABLE(1'b0)) u_crit_lat (
        .clk(clk), .rst_n(rst_n), .set_pulse(crit_edge), .clr_req(crit_clr),
        .state_q(crit_q));
    envmon_event_latch #(.W(N_PSU), .CLEARABLE(1'b1)) u_psu_lat (
        .clk(clk), .rst_n(rst_n), .set_pulse(psu_edge), .clr_req(psu_clr),
        .state_q(psu_q));

    envmon_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_q(ctrl_q));

    // Assemble the read word; unused positions read zero.
    always_comb begin
        rd_data                          = '0;
        rd_data[SINT_LSB +: N_SINT]      = sint_q;
        rd_data[CRIT_LSB +: N_CRIT]      = crit_q;
        rd_data[SMSK_BIT]                = ctrl_q.sint_mask;
        rd_data[NMSK_BIT]                = ctrl_q.nmi_mask;
        rd_data[POFF_BIT]                = ctrl_q.power_off;
        rd_data[PMSK_BIT]                = ctrl_q.psu_mask;
        rd_data[PSU_LSB +: N_PSU]        = psu_q;
    end

    // Form the two interrupt requests and the power-off output.
    always_comb begin
        irq_o       = ((|sint_q) & ~ctrl_q.sint_mask) |
                      ((|psu_q)  & ~ctrl_q.psu_mask);
        nmi_o       = (|crit_q) & ~ctrl_q.nmi_mask;
        power_off_o = ctrl_q.power_off;
    end
endmodule

// File: rtl/envmon_status_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the environmental event register,
// bound to every instance of the top module.
module envmon_status_chk
    import envmon_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             cpu_temp_ok_in,
    input logic             irq_o,
    input logic             nmi_o,
    input logic             power_off_o
);
    // R1: the cycle after reset shows the reset word
    a_r1_reset_word: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_data == reset_word() && !irq_o && !nmi_o));

    // R2: bit 0 rises only after its source was high
    a_r2_set_by_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[0]) |-> $past(cpu_temp_ok_in));

    // R3: bit 0 falls only because of a clearing write
    a_r3_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[0]) |-> $past(wr_en && wr_data[0]));

    // R5: critical bits are sticky
    a_r5_crit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3] |=> rd_data[3]));
    a_r5_crit2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] |=> rd_data[4]));

    // R6: maskable request agrees with register contents
    a_r6_irq_rule: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (((|rd_data[2:0]) && !rd_data[5]) ||
                  ((|rd_data[10:9]) && !rd_data[8])));

    // R7: non-maskable request agrees with register contents
    a_r7_nmi_rule: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o == ((|rd_data[4:3]) && !rd_data[6]));

    // R8: power-off output matches its bit
    a_r8_power_follow: assert property (@(posedge clk) disable iff (!rst_n)
        power_off_o == rd_data[7]);

    // R9: reserved bits read zero
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:11] == 5'd0);

    // R10: a write loads the mask bits
    a_r10_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[5] == $past(wr_data[5]) &&
                   rd_data[6] == $past(wr_data[6]) &&
                   rd_data[8] == $past(wr_data[8])));
endmodule

bind envmon_status_reg envmon_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cpu_temp_ok_in(cpu_temp_ok_in),
    .irq_o(irq_o), .nmi_o(nmi_o), .power_off_o(power_off_o));

// File: tb/envmon_status_reg_test.sv
`timescale 1ns/1ps
// Bench: exhaustive mask x event-pattern sweep plus directed corner cases.
module envmon_status_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        t_ok = 0, t_fail = 0, fan = 0, crit_t = 0, crit_f = 0;
    logic        p1 = 1, p2 = 1;
    logic        irq_o, nmi_o, power_off_o;
    int          n_checks = 0, n_fail = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    envmon_status_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cpu_temp_ok_in(t_ok), .cpu_temp_fail_in(t_fail),
        .encl_fan_fail_in(fan), .encl_temp_crit_in(crit_t),
        .cpu_fan_crit_in(crit_f), .psu1_good_in(p1), .psu2_good_in(p2),
        .irq_o(irq_o), .nmi_o(nmi_o), .power_off_o(power_off_o));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr_en = 0;
        t_ok = 0; t_fail = 0; fan = 0; crit_t = 0; crit_f = 0; p1 = 1; p2 = 1;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 word", rd_data, 16'h0160);
        chk("R1 outs", {13'd0, irq_o, nmi_o, power_off_o}, 16'h0);

        // Sweep: all masks x all event patterns (R2 R4 R5 R6 R7 R9 R10 R3)
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 128; p++) begin
                logic [15:0] mw, exp;
                logic ei, en;
                do_reset();
                mw = 16'hF800 | ({15'd0, m[0]} << 5) | ({15'd0, m[1]} << 6)
                     | ({15'd0, m[2]} << 8);
                wr(mw);
                chk("R10 masks", rd_data, mw & 16'h0160);
                t_ok = p[0]; t_fail = p[1]; fan = p[2]; crit_t = p[3]; crit_f = p[4];
                p1 = p[5] ? 1'b0 : 1'b1; p2 = p[6] ? 1'b0 : 1'b1;
                @(negedge clk);
                t_ok = 0; t_fail = 0; fan = 0; crit_t = 0; crit_f = 0;
                exp = (mw & 16'h0160) | {5'd0, p[6], p[5], 4'd0, p[4:0]};
                @(negedge clk);
                chk("R2/R4/R5/R9 events", rd_data, exp);
                ei = ((|p[2:0]) && !m[0]) || ((|p[6:5]) && !m[2]);
                en = (|p[4:3]) && !m[1];
                chk("R6 irq", {15'd0, irq_o}, {15'd0, ei});
                chk("R7 nmi", {15'd0, nmi_o}, {15'd0, en});
                // R3 clear all clearable bits; R5 crit bits stay
                wr(16'hFE1F & ~16'h0160 | (mw & 16'h0160));
                exp = (mw & 16'h0160) | {11'd0, p[4:3], 3'd0};
                chk("R3/R5 after clear", rd_data, exp);
                chk("R6 irq after clear", {15'd0, irq_o}, 16'h0);
                chk("R7 nmi after clear", {15'd0, nmi_o}, {15'd0, en});
            end
        end

        // R2: held level does not re-set after clearing
        do_reset();
        t_fail = 1; @(negedge clk);
        chk("R2 set", rd_data & 16'h0002, 16'h0002);
        wr(16'h0162);
        @(negedge clk); @(negedge clk);
        chk("R2 held no reset", rd_data & 16'h0002, 16'h0000);
        t_fail = 0; @(negedge clk); t_fail = 1; @(negedge clk);
        chk("R2 new edge", rd_data & 16'h0002, 16'h0002);

        // R3: write of 0 leaves bit; same-cycle edge and clear -> set
        do_reset();
        t_ok = 1; @(negedge clk); t_ok = 0;
        wr(16'h0160);
        chk("R3 write0 keeps", rd_data & 16'h0001, 16'h0001);
        wr_en = 1; wr_data = 16'h0161; t_ok = 1;
        @(negedge clk); wr_en = 0; t_ok = 0;
        chk("R3 set wins", rd_data & 16'h0001, 16'h0001);

        // R4: falling then rising edge of supply 1
        do_reset();
        p1 = 0; @(negedge clk);
        chk("R4 fall", rd_data & 16'h0600, 16'h0200);
        wr(16'h0360);
        chk("R4 cleared", rd_data & 16'h0600, 16'h0000);
        p1 = 1; @(negedge clk);
        chk("R4 rise", rd_data & 16'h0600, 16'h0200);

        // R5: writes of 1 to crit bits do not change them
        do_reset();
        wr(16'h0178);
        chk("R5 write ignored", rd_data & 16'h0018, 16'h0000);

        // R8: power-off write 1 then 0
        wr(16'h01E0);
        chk("R8 on", {15'd0, power_off_o}, 16'h1);
        wr(16'h0160);
        chk("R8 off", {15'd0, power_off_o}, 16'h0);

        // R9: writing reserved ones has no effect
        wr(16'hF960);
        chk("R9 reserved", rd_data, 16'h0160);

        // R1: source high across reset release sets nothing
        @(negedge clk); rst_n = 0; t_ok = 1; crit_t = 1; p2 = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        @(negedge clk); @(negedge clk);
        chk("R1 no edge at release", rd_data, 16'h0160);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #600000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule